// File: doc/BRIEF.md
# Serial Port Control and Status Register File

This block is the software-facing register file of a FIFO-based serial port. A simple bus with byte-spaced word offsets reaches byte-wide registers for the mode, the bit rate, the control bits, the FIFO control and the port pins. It also reaches a status register, the transmit and receive data windows, a receive fill-count window and a line-status window. The receive FIFO and the shift registers live outside this block. They report events on single-cycle strobes and take configuration, the transmit byte and a FIFO-reset pulse back through ports.

Status flags are sticky. A hardware strobe sets a flag. Software clears it by writing a 0 to its bit, and a written 1 leaves it unchanged. When a hardware set and a software clear land in the same cycle, the set wins. Control writes have side effects: a write with the transmitter disabled raises transmit-end, and a write that drops the receive-interrupt enable withdraws the receive interrupt. The transmit interrupt line follows control bit 7.

Top module: `serial_csr`

## Requirements
- R1: After reset the block reads as follows: status 0x60 (transmit-end and transmit-empty set), bit rate 0xFF, control 0x20, mode 0x00, port 0x00, FIFO control 0x00. Both interrupt lines are low.
- R2: Register offsets are: mode 0x00, bit rate 0x04, control 0x08, transmit data 0x0C, status 0x10, receive data 0x14, FIFO control 0x18, fill count 0x1C, port 0x20, line status 0x24. Writes are ANDed with a per-register mask: mode 0x7B, control 0xFA, port 0xF3. Bit rate and FIFO control keep all 8 bits.
- R3: Status bit positions are: transmit-end bit 6, transmit-empty bit 5, break bit 4, receive-full bit 1, data-ready bit 0. Bits 7, 3 and 2 read zero.
- R4: In a status write, a flag whose bit is written 0 clears, and a flag whose bit is written 1 keeps its value.
- R5: A set strobe and a software clear of the same flag in the same cycle leave the flag set.
- R6: A control write with bit 5 at 0 sets transmit-end. The transmit interrupt output equals the stored control bit 7.
- R7: The receive interrupt rises the cycle after a receive-full or data-ready strobe, but only while control bit 6 is 1. It falls after a status write that zeroes bit 1 or bit 0, or after a control write with bit 6 at 0.
- R8: A write to the transmit-data offset clears transmit-empty. It also presents the byte on the transmit data output with a one-cycle valid pulse in the following cycle.
- R9: The break, data-ready, receive-full, transmit-empty and transmit-end strobes each set their flag in the next cycle.
- R10: The receive trigger output carries FIFO-control bits 7:6. A FIFO-control write with bit 1 set gives a one-cycle FIFO-reset pulse in the following cycle.
- R11: The fill-count offset reads the fill-count input zero-extended to 16 bits. Line status reads zero and ignores writes. Unmapped offsets read zero.
- R12: A read of the receive-data offset returns the receive-data input. It pops the FIFO in that same cycle only when the fill count is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (only receive-data reads have a side effect) |
| bus_addr | input | 6 | Byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 16 | Read data, combinational from bus_addr |
| set_tend | input | 1 | Transmit-end event strobe |
| set_tde | input | 1 | Transmit-empty event strobe |
| set_brk | input | 1 | Break event strobe |
| set_rdf | input | 1 | Receive FIFO reached trigger level |
| set_dr | input | 1 | Receive data-ready strobe |
| rx_count | input | 5 | Receive FIFO fill count |
| rx_data | input | 8 | Receive FIFO head byte |
| rx_pop | output | 1 | Pop the receive FIFO |
| tx_data | output | 8 | Transmit byte |
| tx_valid | output | 1 | Transmit byte valid pulse |
| fifo_reset | output | 1 | FIFO reset pulse |
| rx_trig | output | 2 | Receive trigger code |
| mode_q | output | 8 | Stored mode register |
| baud_q | output | 8 | Stored bit-rate register |
| ctrl_q | output | 8 | Stored control register |
| port_q | output | 8 | Stored port register |
| irq_tx | output | 1 | Transmit interrupt |
| irq_rx | output | 1 | Receive interrupt |

## Verification
Status writes are applied with all-ones, single-zero and all-zero patterns. These show a kept flag apart from a cleared one, and a clear of the wrong bit apart from the right one. A status clear is also issued together with a break strobe, which separates set-wins priority from clear-wins. Each masked register is written with 0xFF, which exposes every masked-off bit. Control writes with bit 5 and bit 6 each at 1 and at 0 separate the side effects from the plain stores. Receive-data reads at zero and nonzero fill count show whether the pop is gated.

// File: rtl/serial_csr_pkg.sv
package serial_csr_pkg;
  localparam int REG_W = 8;
  localparam int NREG  = 10;

  // register slot index; byte offset = slot * 4
  localparam int IDX_MODE = 0;
  localparam int IDX_BAUD = 1;
  localparam int IDX_CTRL = 2;
  localparam int IDX_TXD  = 3;
  localparam int IDX_STAT = 4;
  localparam int IDX_RXD  = 5;
  localparam int IDX_FCTL = 6;
  localparam int IDX_CNT  = 7;
  localparam int IDX_PORT = 8;
  localparam int IDX_LSR  = 9;

  localparam logic [REG_W-1:0] MASK_MODE = 8'h7B;
  localparam logic [REG_W-1:0] MASK_CTRL = 8'hFA;
  localparam logic [REG_W-1:0] MASK_PORT = 8'hF3;
  localparam logic [REG_W-1:0] RST_BAUD  = 8'hFF;
  localparam logic [REG_W-1:0] RST_CTRL  = 8'h20;

  typedef struct packed {
    logic tend;
    logic tde;
    logic brk;
    logic rdf;
    logic dr;
  } flags_t;

  function automatic logic [REG_W-1:0] pack_status(flags_t f);
    return {1'b0, f.tend, f.tde, f.brk, 2'b00, f.rdf, f.dr};
  endfunction

  // sticky flag update: set dominates clear
  function automatic logic flag_next(logic q, logic set, logic clr);
    return set ? 1'b1 : (clr ? 1'b0 : q);
  endfunction

  function automatic logic [REG_W-1:0] apply_mask(logic [REG_W-1:0] v,
                                                  logic [REG_W-1:0] m);
    return v & m;
  endfunction
endpackage

// File: rtl/serial_csr_decode.sv
module serial_csr_decode
  import serial_csr_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output logic [NREG-1:0]   hit,
  output logic [NREG-1:0]   wr_hit
);
  for (genvar i = 0; i < NREG; i++) begin : g_slot
    assign hit[i]    = (addr == ADDR_W'(i * 4));
    assign wr_hit[i] = hit[i] & wr;
  end

  always_comb begin
    a_onehot_decode_r2 : assert ($onehot0(hit));
  end
endmodule

// File: rtl/serial_csr_cfg.sv
module serial_csr_cfg
  import serial_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NREG-1:0]  wr_hit,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] mode_q,
  output logic [REG_W-1:0] baud_q,
  output logic [REG_W-1:0] ctrl_q,
  output logic [REG_W-1:0] fctl_q,
  output logic [REG_W-1:0] port_q,
  output logic [REG_W-1:0] txd_q,
  output logic             txv_q,
  output logic             frst_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      baud_q <= RST_BAUD;
      ctrl_q <= RST_CTRL;
      fctl_q <= '0;
      port_q <= '0;
      txd_q  <= '0;
      txv_q  <= 1'b0;
      frst_q <= 1'b0;
    end else begin
      if (wr_hit[IDX_MODE]) mode_q <= apply_mask(wdata, MASK_MODE);
      if (wr_hit[IDX_BAUD]) baud_q <= wdata;
      if (wr_hit[IDX_CTRL]) ctrl_q <= apply_mask(wdata, MASK_CTRL);
      if (wr_hit[IDX_FCTL]) fctl_q <= wdata;
      if (wr_hit[IDX_PORT]) port_q <= apply_mask(wdata, MASK_PORT);
      if (wr_hit[IDX_TXD])  txd_q  <= wdata;
      txv_q  <= wr_hit[IDX_TXD];
      frst_q <= wr_hit[IDX_FCTL] & wdata[1];
    end
  end

  p_fifo_pulse_r10 : assert property (@(posedge clk) disable iff (!rst_n)
    frst_q |-> $past(wr_hit[IDX_FCTL] && wdata[1]));
  p_ctrl_mask_r2 : assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit[IDX_CTRL] |=> (ctrl_q[0] == 1'b0 && ctrl_q[2] == 1'b0));
endmodule

// File: rtl/serial_csr_status.sv
module serial_csr_status
  import serial_csr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wr_stat,
  input  flags_t keep,
  input  logic   wr_txd,
  input  logic   tx_off_wr,
  input  logic   wr_ctrl,
  input  logic   rx_ie_next,
  input  flags_t ev_set,
  output flags_t flags_q,
  output logic   irq_rx_q
);
  flags_t clr;
  flags_t nxt;
  flags_t set_all;
  logic   irq_set, irq_clr;

  always_comb begin
    clr.tend = wr_stat & ~keep.tend;
    clr.tde  = (wr_stat & ~keep.tde) | wr_txd;
    clr.brk  = wr_stat & ~keep.brk;
    clr.rdf  = wr_stat & ~keep.rdf;
    clr.dr   = wr_stat & ~keep.dr;
    set_all      = ev_set;
    set_all.tend = ev_set.tend | tx_off_wr;
    nxt.tend = flag_next(flags_q.tend, set_all.tend, clr.tend);
    nxt.tde  = flag_next(flags_q.tde,  set_all.tde,  clr.tde);
    nxt.brk  = flag_next(flags_q.brk,  set_all.brk,  clr.brk);
    nxt.rdf  = flag_next(flags_q.rdf,  set_all.rdf,  clr.rdf);
    nxt.dr   = flag_next(flags_q.dr,   set_all.dr,   clr.dr);
  end

  assign irq_set = (ev_set.rdf | ev_set.dr) & rx_ie_next;
  assign irq_clr = (wr_stat & (~keep.rdf | ~keep.dr)) | (wr_ctrl & ~rx_ie_next);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q  <= '{tend: 1'b1, tde: 1'b1, brk: 1'b0, rdf: 1'b0, dr: 1'b0};
      irq_rx_q <= 1'b0;
    end else begin
      flags_q  <= nxt;
      irq_rx_q <= flag_next(irq_rx_q, irq_set, irq_clr);
    end
  end

  p_brk_event_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    ev_set.brk |=> flags_q.brk);
  p_set_wins_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    (ev_set.tend && wr_stat && !keep.tend) |=> flags_q.tend);
  p_irq_drop_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !irq_set) |=> !irq_rx_q);
  p_tde_clear_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    (wr_txd && !ev_set.tde) |=> !flags_q.tde);
endmodule

// File: rtl/serial_csr.sv
module serial_csr
  import serial_csr_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 16,
  parameter int FIFO_DEPTH = 16,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              set_tend,
  input  logic              set_tde,
  input  logic              set_brk,
  input  logic              set_rdf,
  input  logic              set_dr,
  input  logic [CNT_W-1:0]  rx_count,
  input  logic [REG_W-1:0]  rx_data,
  output logic              rx_pop,
  output logic [REG_W-1:0]  tx_data,
  output logic              tx_valid,
  output logic              fifo_reset,
  output logic [1:0]        rx_trig,
  output logic [REG_W-1:0]  mode_q,
  output logic [REG_W-1:0]  baud_q,
  output logic [REG_W-1:0]  ctrl_q,
  output logic [REG_W-1:0]  port_q,
  output logic              irq_tx,
  output logic              irq_rx
);
  logic [NREG-1:0]  hit, wr_hit;
  logic [REG_W-1:0] fctl_q;
  flags_t           flags_q, keep, ev_set;

  serial_csr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .wr(bus_wr), .hit(hit), .wr_hit(wr_hit));

  serial_csr_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .wdata(bus_wdata),
    .mode_q(mode_q), .baud_q(baud_q), .ctrl_q(ctrl_q), .fctl_q(fctl_q),
    .port_q(port_q), .txd_q(tx_data), .txv_q(tx_valid), .frst_q(fifo_reset));

  assign keep   = '{tend: bus_wdata[6], tde: bus_wdata[5], brk: bus_wdata[4],
                    rdf: bus_wdata[1], dr: bus_wdata[0]};
  assign ev_set = '{tend: set_tend, tde: set_tde, brk: set_brk,
                    rdf: set_rdf, dr: set_dr};

  // receive-interrupt enable as it will be after this cycle
  logic rx_ie_next;
  assign rx_ie_next = wr_hit[IDX_CTRL] ? bus_wdata[6] : ctrl_q[6];

  serial_csr_status u_stat (
    .clk(clk), .rst_n(rst_n),
    .wr_stat(wr_hit[IDX_STAT]), .keep(keep),
    .wr_txd(wr_hit[IDX_TXD]),
    .tx_off_wr(wr_hit[IDX_CTRL] & ~bus_wdata[5]),
    .wr_ctrl(wr_hit[IDX_CTRL]), .rx_ie_next(rx_ie_next),
    .ev_set(ev_set), .flags_q(flags_q), .irq_rx_q(irq_rx));

  assign irq_tx  = ctrl_q[7];
  assign rx_trig = fctl_q[7:6];
  assign rx_pop  = bus_rd & hit[IDX_RXD] & (rx_count != '0);

  always_comb begin
    bus_rdata = '0;
    if (hit[IDX_MODE]) bus_rdata = DATA_W'(mode_q);
    if (hit[IDX_BAUD]) bus_rdata = DATA_W'(baud_q);
    if (hit[IDX_CTRL]) bus_rdata = DATA_W'(ctrl_q);
    if (hit[IDX_STAT]) bus_rdata = DATA_W'(pack_status(flags_q));
    if (hit[IDX_RXD])  bus_rdata = DATA_W'(rx_data);
    if (hit[IDX_FCTL]) bus_rdata = DATA_W'(fctl_q);
    if (hit[IDX_CNT])  bus_rdata = DATA_W'(rx_count);
    if (hit[IDX_PORT]) bus_rdata = DATA_W'(port_q);
  end

  p_txdata_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(IDX_TXD * 4)) |=>
      (tx_valid && tx_data == $past(bus_wdata)));
  p_pop_gate_r12 : assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |-> (bus_rd && rx_count != '0));
  p_irq_tx_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(IDX_CTRL * 4)) |=> (irq_tx == $past(bus_wdata[7])));
endmodule

// File: tb/serial_csr_tb.sv
module serial_csr_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [5:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        set_tend = 0, set_tde = 0, set_brk = 0, set_rdf = 0, set_dr = 0;
  logic [4:0]  rx_count = '0;
  logic [7:0]  rx_data = '0;
  logic        rx_pop, tx_valid, fifo_reset, irq_tx, irq_rx;
  logic [7:0]  tx_data, mode_q, baud_q, ctrl_q, port_q;
  logic [1:0]  rx_trig;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  serial_csr u_dut (.*);

  localparam logic [5:0] A_MODE = 6'h00, A_BAUD = 6'h04, A_CTRL = 6'h08,
    A_TXD = 6'h0C, A_STAT = 6'h10, A_RXD = 6'h14, A_FCTL = 6'h18,
    A_CNT = 6'h1C, A_PORT = 6'h20, A_LSR = 6'h24;

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd_chk(string req, logic [5:0] a, logic [15:0] exp);
    @(negedge clk); bus_addr = a; #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic t_reset;
    rd_chk("R1 status", A_STAT, 16'h0060);
    rd_chk("R1 baud",   A_BAUD, 16'h00FF);
    rd_chk("R1 ctrl",   A_CTRL, 16'h0020);
    rd_chk("R1 mode",   A_MODE, 16'h0000);
    rd_chk("R1 port",   A_PORT, 16'h0000);
    rd_chk("R1 fctl",   A_FCTL, 16'h0000);
    check("R1 irq", {irq_tx, irq_rx}, 2'b00);
  endtask

  task automatic t_masks;
    wr(A_MODE, 8'hFF); rd_chk("R2 mode mask", A_MODE, 16'h007B);
    wr(A_CTRL, 8'hFF); rd_chk("R2 ctrl mask", A_CTRL, 16'h00FA);
    check("R6 irq_tx high", irq_tx, 1'b1);
    wr(A_PORT, 8'hFF); rd_chk("R2 port mask", A_PORT, 16'h00F3);
    wr(A_BAUD, 8'h5A); rd_chk("R2 baud", A_BAUD, 16'h005A);
    wr(A_FCTL, 8'hC0); rd_chk("R2 fctl", A_FCTL, 16'h00C0);
    check("R10 trig", rx_trig, 2'd3);
    wr(A_LSR, 8'hFF); rd_chk("R11 line status", A_LSR, 16'h0000);
  endtask

  task automatic t_events;
    @(negedge clk); set_brk = 1; set_dr = 1; set_rdf = 1;
    @(negedge clk); set_brk = 0; set_dr = 0; set_rdf = 0;
    rd_chk("R9 R3 status after events", A_STAT, 16'h0073);
    check("R7 irq_rx rise", irq_rx, 1'b1);
  endtask

  task automatic t_clear;
    wr(A_STAT, 8'hFF); rd_chk("R4 keep all", A_STAT, 16'h0073);
    wr(A_STAT, 8'hEF); rd_chk("R4 clear brk", A_STAT, 16'h0063);
    check("R7 irq kept", irq_rx, 1'b1);
    wr(A_STAT, 8'hFD); rd_chk("R4 clear rdf", A_STAT, 16'h0061);
    check("R7 irq drop by status", irq_rx, 1'b0);
    wr(A_STAT, 8'h00); rd_chk("R4 clear all", A_STAT, 16'h0000);
  endtask

  task automatic t_ctrl;
    wr(A_CTRL, 8'h40); rd_chk("R6 tend by ctrl", A_STAT, 16'h0040);
    check("R6 irq_tx low", irq_tx, 1'b0);
    @(negedge clk); set_dr = 1; @(negedge clk); set_dr = 0;
    check("R7 irq rise dr", irq_rx, 1'b1);
    wr(A_CTRL, 8'h00);
    check("R7 irq drop by ctrl", irq_rx, 1'b0);
    wr(A_STAT, 8'h00);
    @(negedge clk); set_rdf = 1; @(negedge clk); set_rdf = 0;
    check("R7 no irq when disabled", irq_rx, 1'b0);
    rd_chk("R9 rdf set", A_STAT, 16'h0002);
  endtask

  task automatic t_priority;
    @(negedge clk); bus_wr = 1; bus_addr = A_STAT; bus_wdata = 8'h00; set_brk = 1;
    @(negedge clk); bus_wr = 0; set_brk = 0;
    rd_chk("R5 set wins", A_STAT, 16'h0010);
  endtask

  task automatic t_tx;
    @(negedge clk); set_tde = 1; @(negedge clk); set_tde = 0;
    rd_chk("R9 tde set", A_STAT, 16'h0030);
    @(negedge clk); bus_wr = 1; bus_addr = A_TXD; bus_wdata = 8'hA5;
    @(negedge clk); bus_wr = 0;
    check("R8 tx_valid", tx_valid, 1'b1);
    check("R8 tx_data", tx_data, 8'hA5);
    @(negedge clk);
    check("R8 tx_valid one cycle", tx_valid, 1'b0);
    rd_chk("R8 tde cleared", A_STAT, 16'h0010);
  endtask

  task automatic t_fifo;
    @(negedge clk); bus_wr = 1; bus_addr = A_FCTL; bus_wdata = 8'h42;
    @(negedge clk); bus_wr = 0;
    check("R10 reset pulse", fifo_reset, 1'b1);
    check("R10 trig", rx_trig, 2'd1);
    @(negedge clk);
    check("R10 pulse ends", fifo_reset, 1'b0);
    wr(A_FCTL, 8'h80);
    check("R10 no pulse", fifo_reset, 1'b0);
  endtask

  task automatic t_reads;
    rx_count = 5'd9;
    rd_chk("R11 count", A_CNT, 16'h0009);
    rx_count = 5'd16;
    rd_chk("R11 count full", A_CNT, 16'h0010);
    rd_chk("R11 unmapped", 6'h28, 16'h0000);
    rx_count = 5'd0; rx_data = 8'h3C;
    @(negedge clk); bus_addr = A_RXD; bus_rd = 1; #1;
    check("R12 no pop when empty", rx_pop, 1'b0);
    rx_count = 5'd3; #1;
    check("R12 data", bus_rdata, 16'h003C);
    check("R12 pop", rx_pop, 1'b1);
    @(negedge clk); bus_rd = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_masks();
    t_events();
    t_clear();
    t_ctrl();
    t_priority();
    t_tx();
    t_fifo();
    t_reads();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule